// File: doc/BRIEF.md
# I2C Command Front End for a 1-Wire Bridge

This block is the host-facing half of a bridge between an I2C bus and a 1-Wire line. It acts as an I2C slave: it samples SCL and SDA with the system clock, spots START and STOP conditions, matches its own 7-bit address and returns ACK or NACK for each byte by pulling SDA low through an open-drain enable. Write transfers carry a one-byte command that may be followed by one parameter byte. Read transfers return whichever register the read pointer selects, for as many bytes as the master clocks.

The block keeps a 4-bit configuration register, a status view and a read-data register. A separate 1-Wire engine does the line timing. This block sends that engine a one-cycle start strobe with an operation code and an argument byte. It also sends a reset pulse when the host asks for a device reset. The engine reports back a live busy level. It also sends a completion strobe that carries five result flags and a data byte, and the front end latches these for the host to read. Whether a byte is accepted depends on the command, on the engine's busy level and, for configuration writes, on a nibble-complement check.

Top module: `i2c_cmd_frontend`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal 0b00110 followed by the two strap inputs (strap[1] then strap[0]). Bit 0 of the address byte selects the direction: 0 for write and 1 for read. A mismatched address is NACKed, and the block then ignores every byte until the next START or STOP.
- R2: The block accepts the command codes F0h (device reset), E1h (set pointer), D2h (write configuration), B4h (line reset), A5h (write byte), 96h (read byte), 87h (single bit) and 78h (triplet). Any other code is NACKed.
- R3: The parameter of E1h is accepted only as F0h (status), E1h (read data) or C3h (configuration), and it moves the read pointer to that register. Any other value is NACKed and leaves the pointer unchanged.
- R4: A configuration parameter is acknowledged only when bits 7:4 are the bitwise inverse of bits 3:0. It then loads bits 3:0 into the configuration register and onto cfg_bits. A rejected value is NACKed and leaves the register unchanged. Reads of the configuration register return 0 in bits 7:4.
- R5: While eng_busy is 1, the codes D2h, B4h, A5h, 96h, 87h and 78h are NACKed and start nothing. F0h and E1h are accepted at all times.
- R6: F0h and every 1-Wire command leave the read pointer at status. An accepted configuration write leaves it at the configuration register. After reset the pointer is at status.
- R7: After rst_n, and after an F0h command, the configuration reads 00h, RST reads 1 and every other stored status bit reads 0. F0h also gives a one-cycle pulse on eng_rst.
- R8: An accepted configuration write clears RST.
- R9: The status byte is, from bit 7 down to bit 0, {DIR, TSB, SBR, RST, LL, SD, PPD, BUSY}. BUSY is the live eng_busy input. On an eng_done strobe the block loads eng_flags[4:0] into DIR, TSB, SBR, SD and PPD, in that order, and loads eng_rdata into the read-data register.
- R10: LL is loaded from ow_line during the acknowledge of a read address, and only when the pointer is at status.
- R11: In one write transfer, any byte after the expected command and parameter is NACKed. Consecutive bytes of one read transfer all return the pointed-to register.
- R12: An accepted command gives one cmd_go pulse. cmd_op is 0 for line reset, 1 for write byte, 2 for read byte, 3 for single bit and 4 for triplet. Line reset and read byte start at their command byte. The other three start at their parameter byte, and cmd_arg then carries that parameter.
- R13: A STOP or a repeated START that arrives before the parameter of a parameter-taking command drops that command, and no cmd_go follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line as seen on the pin |
| sda_i | input | 1 | I2C data line as seen on the pin |
| sda_oe | output | 1 | Pull SDA low when 1 (open drain) |
| strap | input | STRAP_W | Low address bits from board straps |
| ow_line | input | 1 | Current level of the 1-Wire line |
| eng_busy | input | 1 | Engine is executing a line operation |
| eng_done | input | 1 | One-cycle strobe: flags and data are valid |
| eng_flags | input | 5 | Results {DIR, TSB, SBR, SD, PPD} |
| eng_rdata | input | 8 | Data byte from the engine |
| cfg_bits | output | 4 | Configuration {speed, strong pullup, presence mask, active pullup} |
| cmd_go | output | 1 | One-cycle start strobe to the engine |
| cmd_op | output | 3 | Operation code for the engine |
| cmd_arg | output | 8 | Argument byte for the engine |
| eng_rst | output | 1 | One-cycle reset pulse to the engine |

## Verification
The bench builds the block with its default parameters: two synchronizer stages, a two-bit strap and base address 18h. With the two-bit strap, both strap inputs can be changed during the run to show that the address match follows the pins. The bench includes a small engine model with a busy window of several thousand cycles. That window is long enough to send gated commands, pointer changes and status reads while the engine is busy, and to watch a device reset cut a busy period short.

// File: rtl/fe_pkg.sv
package fe_pkg;
   typedef enum logic [1:0] {PTR_STAT, PTR_RDAT, PTR_CFG} ptr_e;
   typedef enum logic [2:0] {OP_LRST = 3'd0, OP_WRB = 3'd1, OP_RDB = 3'd2,
                             OP_BIT = 3'd3, OP_TRI = 3'd4} op_e;
   localparam int IDX_W = 2;
   localparam logic [7:0] C_DEVRST = 8'hF0;
   localparam logic [7:0] C_SETPTR = 8'hE1;
   localparam logic [7:0] C_WRCFG  = 8'hD2;
   localparam logic [7:0] C_LRST   = 8'hB4;
   localparam logic [7:0] C_WRB    = 8'hA5;
   localparam logic [7:0] C_RDB    = 8'h96;
   localparam logic [7:0] C_BIT    = 8'h87;
   localparam logic [7:0] C_TRI    = 8'h78;
   localparam logic [7:0] SEL_STAT = 8'hF0;
   localparam logic [7:0] SEL_RDAT = 8'hE1;
   localparam logic [7:0] SEL_CFG  = 8'hC3;
endpackage

// File: rtl/fe_sync.sv
module fe_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   if (STAGES < 2) begin : g_bad_depth
      $error("fe_sync needs at least two stages");
   end

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[i] <= 1'b1;
            else        chain[i] <= d;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[i] <= 1'b1;
            else        chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/fe_phy.sv
module fe_phy
   import fe_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_s,
   input  logic             sda_s,
   input  logic             ack_ok,
   input  logic [7:0]       tx_byte,
   output logic             byte_rdy,
   output logic [7:0]       rx_byte,
   output logic             is_addr,
   output logic [IDX_W-1:0] byte_idx,
   output logic             sda_oe
);
   typedef enum logic [2:0] {S_IDLE, S_RX, S_AW, S_AD, S_TX, S_MW, S_MF, S_SKIP} st_e;
   localparam logic [IDX_W-1:0] IDX_MAX = {IDX_W{1'b1}};

   st_e              st;
   logic             scl_q, sda_q;
   logic [6:0]       shreg;
   logic [7:0]       txsh;
   logic [2:0]       bitcnt;
   logic             addr_q, rw_q, ack_q;
   logic [IDX_W-1:0] idx_q;
   logic             scl_rise, scl_fall, start_c, stop_c;

   assign scl_rise = scl_s & ~scl_q;
   assign scl_fall = ~scl_s & scl_q;
   assign start_c  = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_c   = scl_s & scl_q & ~sda_q & sda_s;

   assign rx_byte  = {shreg, sda_s};
   assign byte_rdy = (st == S_RX) && scl_rise && (bitcnt == 3'd7);
   assign is_addr  = addr_q;
   assign byte_idx = idx_q;
   assign sda_oe   = (st == S_AD) ? ack_q : (st == S_TX) ? ~txsh[7] : 1'b0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= S_IDLE; scl_q <= 1'b1; sda_q <= 1'b1; shreg <= '0; txsh <= '1;
         bitcnt <= '0; addr_q <= 1'b0; rw_q <= 1'b0; ack_q <= 1'b0; idx_q <= '0;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
         if (start_c) begin
            st <= S_RX; bitcnt <= '0; addr_q <= 1'b1; idx_q <= '0;
         end else if (stop_c) begin
            st <= S_IDLE; addr_q <= 1'b0;
         end else begin
            case (st)
               S_RX: if (scl_rise) begin
                  shreg  <= rx_byte[6:0];
                  bitcnt <= bitcnt + 3'd1;
                  if (bitcnt == 3'd7) begin
                     ack_q <= ack_ok;
                     st    <= S_AW;
                     if (addr_q) rw_q <= rx_byte[0];
                  end
               end
               S_AW: if (scl_fall) st <= S_AD;
               S_AD: if (scl_fall) begin
                  bitcnt <= '0;
                  addr_q <= 1'b0;
                  if (!ack_q) st <= S_SKIP;
                  else if (addr_q && rw_q) begin
                     txsh <= tx_byte;
                     st   <= S_TX;
                  end else begin
                     st <= S_RX;
                     if (!addr_q && idx_q != IDX_MAX) idx_q <= idx_q + 1'b1;
                  end
               end
               S_TX: if (scl_fall) begin
                  if (bitcnt == 3'd7) st <= S_MW;
                  else begin
                     txsh   <= {txsh[6:0], 1'b1};
                     bitcnt <= bitcnt + 3'd1;
                  end
               end
               S_MW: if (scl_rise) st <= sda_s ? S_SKIP : S_MF;
               S_MF: if (scl_fall) begin
                  txsh <= tx_byte; bitcnt <= '0; st <= S_TX;
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/fe_regs.sv
module fe_regs
   import fe_pkg::*;
#(
   parameter int         STRAP_W   = 2,
   parameter logic [6:0] ADDR_BASE = 7'h18
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               byte_rdy,
   input  logic [7:0]         rx_byte,
   input  logic               is_addr,
   input  logic [IDX_W-1:0]   byte_idx,
   input  logic [STRAP_W-1:0] strap,
   input  logic               ow_line,
   input  logic               eng_busy,
   input  logic               eng_done,
   input  logic [4:0]         eng_flags,
   input  logic [7:0]         eng_rdata,
   output logic               ack_ok,
   output logic [7:0]         tx_byte,
   output logic [3:0]         cfg_bits,
   output logic               cmd_go,
   output logic [2:0]         cmd_op,
   output logic [7:0]         cmd_arg,
   output logic               eng_rst
);
   localparam int HI_W = 7 - STRAP_W;

   ptr_e       ptr_q, ptr_n;
   op_e        op_q, op_n;
   logic [3:0] cfg_q;
   logic       rst_q, ll_q, go_q, erst_q;
   logic [4:0] flags_q;
   logic [7:0] rdata_q, code_q, arg_q, arg_n;
   logic [6:0] my_addr;
   logic       do_rst, do_cfg, do_ptr, do_go, do_ll, is_cmd, is_par;

   assign my_addr = {ADDR_BASE[6 -: HI_W], strap};
   assign is_cmd  = byte_rdy && !is_addr && byte_idx == 2'd0;
   assign is_par  = byte_rdy && !is_addr && byte_idx == 2'd1;

   always_comb begin
      ack_ok = 1'b0; do_rst = 1'b0; do_cfg = 1'b0; do_ptr = 1'b0;
      do_go = 1'b0; do_ll = 1'b0; ptr_n = PTR_STAT; op_n = OP_LRST; arg_n = rx_byte;
      if (byte_rdy && is_addr) begin
         ack_ok = (rx_byte[7:1] == my_addr);
         do_ll  = ack_ok && rx_byte[0] && (ptr_q == PTR_STAT);
      end else if (is_cmd) begin
         case (rx_byte)
            C_DEVRST: begin ack_ok = 1'b1; do_rst = 1'b1; end
            C_SETPTR: ack_ok = 1'b1;
            C_WRCFG, C_WRB, C_BIT, C_TRI: ack_ok = !eng_busy;
            C_LRST, C_RDB: begin
               ack_ok = !eng_busy;
               do_go  = ack_ok;
               do_ptr = ack_ok;
               op_n   = (rx_byte == C_LRST) ? OP_LRST : OP_RDB;
            end
            default: ack_ok = 1'b0;
         endcase
      end else if (is_par) begin
         case (code_q)
            C_SETPTR: begin
               ack_ok = 1'b1;
               case (rx_byte)
                  SEL_STAT: ptr_n = PTR_STAT;
                  SEL_RDAT: ptr_n = PTR_RDAT;
                  SEL_CFG:  ptr_n = PTR_CFG;
                  default:  ack_ok = 1'b0;
               endcase
               do_ptr = ack_ok;
            end
            C_WRCFG: begin
               ack_ok = (rx_byte[7:4] == ~rx_byte[3:0]);
               do_cfg = ack_ok;
               do_ptr = ack_ok;
               ptr_n  = PTR_CFG;
            end
            C_WRB, C_BIT, C_TRI: begin
               ack_ok = 1'b1; do_go = 1'b1; do_ptr = 1'b1;
               op_n   = (code_q == C_WRB) ? OP_WRB : (code_q == C_BIT) ? OP_BIT : OP_TRI;
            end
            default: ack_ok = 1'b0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= PTR_STAT; op_q <= OP_LRST; cfg_q <= '0; rst_q <= 1'b1; ll_q <= 1'b0;
         go_q <= 1'b0; erst_q <= 1'b0; flags_q <= '0; rdata_q <= '0; code_q <= '0;
         arg_q <= '0;
      end else begin
         go_q   <= 1'b0;
         erst_q <= 1'b0;
         if (is_cmd && ack_ok) code_q <= rx_byte;
         if (do_rst) begin
            cfg_q <= '0; rst_q <= 1'b1; flags_q <= '0; ll_q <= 1'b0;
            ptr_q <= PTR_STAT; erst_q <= 1'b1;
         end else begin
            if (eng_done) begin flags_q <= eng_flags; rdata_q <= eng_rdata; end
            if (do_cfg) begin cfg_q <= rx_byte[3:0]; rst_q <= 1'b0; end
            if (do_ptr) ptr_q <= ptr_n;
            if (do_ll) ll_q <= ow_line;
            if (do_go) begin go_q <= 1'b1; op_q <= op_n; arg_q <= arg_n; end
         end
      end
   end

   always_comb begin
      case (ptr_q)
         PTR_RDAT: tx_byte = rdata_q;
         PTR_CFG:  tx_byte = {4'h0, cfg_q};
         default:  tx_byte = {flags_q[4:2], rst_q, ll_q, flags_q[1:0], eng_busy};
      endcase
   end

   assign cfg_bits = cfg_q;
   assign cmd_go   = go_q;
   assign cmd_op   = op_q;
   assign cmd_arg  = arg_q;
   assign eng_rst  = erst_q;
endmodule

// File: rtl/i2c_cmd_frontend.sv
module i2c_cmd_frontend
   import fe_pkg::*;
#(
   parameter int         SYNC_STAGES = 2,
   parameter int         STRAP_W     = 2,
   parameter logic [6:0] ADDR_BASE   = 7'h18
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_i,
   input  logic               sda_i,
   output logic               sda_oe,
   input  logic [STRAP_W-1:0] strap,
   input  logic               ow_line,
   input  logic               eng_busy,
   input  logic               eng_done,
   input  logic [4:0]         eng_flags,
   input  logic [7:0]         eng_rdata,
   output logic [3:0]         cfg_bits,
   output logic               cmd_go,
   output logic [2:0]         cmd_op,
   output logic [7:0]         cmd_arg,
   output logic               eng_rst
);
   if (STRAP_W < 1 || STRAP_W > 3) begin : g_bad_strap
      $error("STRAP_W must be between 1 and 3");
   end

   logic             scl_s, sda_s, byte_rdy, is_addr, ack_ok;
   logic [7:0]       rx_byte, tx_byte;
   logic [IDX_W-1:0] byte_idx;

   fe_sync #(.STAGES(SYNC_STAGES)) u_scl (.clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s));
   fe_sync #(.STAGES(SYNC_STAGES)) u_sda (.clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s));

   fe_phy u_phy (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s), .ack_ok(ack_ok),
      .tx_byte(tx_byte), .byte_rdy(byte_rdy), .rx_byte(rx_byte), .is_addr(is_addr),
      .byte_idx(byte_idx), .sda_oe(sda_oe));

   fe_regs #(.STRAP_W(STRAP_W), .ADDR_BASE(ADDR_BASE)) u_regs (
      .clk(clk), .rst_n(rst_n), .byte_rdy(byte_rdy), .rx_byte(rx_byte),
      .is_addr(is_addr), .byte_idx(byte_idx), .strap(strap), .ow_line(ow_line),
      .eng_busy(eng_busy), .eng_done(eng_done), .eng_flags(eng_flags),
      .eng_rdata(eng_rdata), .ack_ok(ack_ok), .tx_byte(tx_byte), .cfg_bits(cfg_bits),
      .cmd_go(cmd_go), .cmd_op(cmd_op), .cmd_arg(cmd_arg), .eng_rst(eng_rst));
endmodule

// File: rtl/fe_checker.sv
module fe_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       scl_s,
   input logic       sda_oe,
   input logic       cmd_go,
   input logic       eng_busy,
   input logic       eng_rst,
   input logic [3:0] cfg_bits
);
   AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_s); // R1
   AST_GO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_go |=> !cmd_go); // R12
   AST_GO_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_go |-> !eng_busy); // R5
   AST_RST_CFG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      eng_rst |-> cfg_bits == 4'h0); // R7
   AST_RST_NO_GO: assert property (@(posedge clk) disable iff (!rst_n)
      eng_rst |-> !cmd_go); // R7
endmodule

bind i2c_cmd_frontend fe_checker u_chk (
   .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe), .cmd_go(cmd_go),
   .eng_busy(eng_busy), .eng_rst(eng_rst), .cfg_bits(cfg_bits));

// File: tb/sim_i2c_cmd_frontend.sv
module sim_i2c_cmd_frontend;
   localparam int Q = 10;
   localparam int BUSY_CYC = 3000;
   // {parameter byte, expected ack, expected configuration}
   localparam logic [12:0] CFG_VEC [8] = '{
      {8'hE1, 1'b1, 4'h1}, {8'h87, 1'b1, 4'h7}, {8'hF0, 1'b1, 4'h0}, {8'h11, 1'b0, 4'h0},
      {8'hB4, 1'b1, 4'h4}, {8'hFF, 1'b0, 4'h4}, {8'h0F, 1'b1, 4'hF}, {8'h78, 1'b1, 4'h8}};

   logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1, ow_line = 1'b1;
   logic [1:0] strap = 2'b10;
   logic sda_oe, cmd_go, eng_rst, sda_bus;
   logic [3:0] cfg_bits;
   logic [2:0] cmd_op;
   logic [7:0] cmd_arg;
   logic eng_busy = 1'b0, eng_done = 1'b0;
   logic [4:0] eng_flags = '0;
   logic [7:0] eng_rdata = '0;
   int busy_cnt = 0, go_cnt = 0, rst_cnt = 0, n_chk = 0, n_fail = 0;
   logic [2:0] last_op = '0;
   logic [7:0] last_arg = '0;
   logic [6:0] addr;
   bit finished = 0;

   always #2 clk = ~clk;
   assign sda_bus = sda_m & ~sda_oe;
   assign addr = {5'b00110, strap};

   i2c_cmd_frontend u0 (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
      .strap(strap), .ow_line(ow_line), .eng_busy(eng_busy), .eng_done(eng_done),
      .eng_flags(eng_flags), .eng_rdata(eng_rdata), .cfg_bits(cfg_bits),
      .cmd_go(cmd_go), .cmd_op(cmd_op), .cmd_arg(cmd_arg), .eng_rst(eng_rst));

   // engine model
   always @(posedge clk) begin
      eng_done <= 1'b0;
      if (eng_rst) begin
         eng_busy <= 1'b0; busy_cnt <= 0; rst_cnt <= rst_cnt + 1;
      end else if (cmd_go) begin
         eng_busy <= 1'b1; busy_cnt <= BUSY_CYC; go_cnt <= go_cnt + 1;
         last_op <= cmd_op; last_arg <= cmd_arg;
      end else if (eng_busy) begin
         busy_cnt <= busy_cnt - 1;
         if (busy_cnt == 1) begin
            eng_busy <= 1'b0; eng_done <= 1'b1;
            eng_flags <= (last_op == 3'd0) ? 5'b00001 : (last_op == 3'd2) ? 5'b00000 : last_arg[4:0];
            eng_rdata <= (last_op == 3'd2) ? 8'h3C : last_arg;
         end
      end
   end

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic wq(); repeat (Q) @(negedge clk); endtask
   task automatic i2c_start(); sda_m = 1; wq(); scl_m = 1; wq(); sda_m = 0; wq(); scl_m = 0; wq(); endtask
   task automatic i2c_stop(); sda_m = 0; wq(); scl_m = 1; wq(); sda_m = 1; wq(); endtask
   task automatic put_bit(input logic b); sda_m = b; wq(); scl_m = 1; wq(); wq(); scl_m = 0; wq(); endtask
   task automatic get_bit(output logic b); sda_m = 1; wq(); scl_m = 1; wq(); b = sda_bus; wq(); scl_m = 0; wq(); endtask

   task automatic wr_byte(input logic [7:0] v, output logic ack);
      logic x;
      for (int i = 7; i >= 0; i--) put_bit(v[i]);
      get_bit(x);
      ack = ~x;
   endtask

   task automatic rd_byte(input logic nack, output logic [7:0] v);
      logic x;
      for (int i = 7; i >= 0; i--) begin get_bit(x); v[i] = x; end
      put_bit(nack);
   endtask

   task automatic cmd_tx(input logic [7:0] c, input logic [7:0] p, input int np,
                         output logic ac, output logic ap);
      logic aa;
      ap = 0;
      i2c_start();
      wr_byte({addr, 1'b0}, aa);
      wr_byte(c, ac);
      if (np != 0) wr_byte(p, ap);
      i2c_stop();
   endtask

   task automatic read_reg(output logic [7:0] v);
      logic aa;
      i2c_start();
      wr_byte({addr, 1'b1}, aa);
      rd_byte(1'b1, v);
      i2c_stop();
   endtask

   task automatic wait_idle(); repeat (BUSY_CYC + 200) @(negedge clk); endtask

   initial begin
      logic a0, a1;
      logic [7:0] d, d2;
      int g;
      repeat (5) @(negedge clk);
      rst_n = 1;
      repeat (5) @(negedge clk);

      // reset state
      chk("R7 sda_oe idle", {7'd0, sda_oe}, 8'h00);
      chk("R7 cfg after reset", {4'h0, cfg_bits}, 8'h00);
      read_reg(d);
      chk("R7 R9 status after reset", d, 8'h18);

      // wrong address
      i2c_start();
      wr_byte({5'b00110, 2'b01, 1'b0}, a0);
      chk("R1 mismatched address nack", {7'd0, a0}, 8'h00);
      wr_byte(C_DEV, a1);
      chk("R1 ignored after mismatch", {7'd0, a1}, 8'h00);
      i2c_stop();

      // configuration table
      for (int k = 0; k < 8; k++) begin
         cmd_tx(8'hD2, CFG_VEC[k][12:5], 1, a0, a1);
         chk($sformatf("R4 cfg byte %h ack", CFG_VEC[k][12:5]), {7'd0, a1}, {7'd0, CFG_VEC[k][4]});
         chk("R4 cfg_bits port", {4'h0, cfg_bits}, {4'h0, CFG_VEC[k][3:0]});
         cmd_tx(8'hE1, 8'hC3, 1, a0, a1);
         read_reg(d);
         chk("R4 cfg readback", d, {4'h0, CFG_VEC[k][3:0]});
      end
      cmd_tx(8'hE1, 8'hF0, 1, a0, a1);
      read_reg(d);
      chk("R8 RST cleared", d, 8'h08);

      // pointer after configuration write
      cmd_tx(8'hD2, 8'hE1, 1, a0, a1);
      read_reg(d);
      chk("R6 pointer at cfg", d, 8'h01);
      cmd_tx(8'hE1, 8'h55, 1, a0, a1);
      chk("R3 invalid pointer nack", {7'd0, a1}, 8'h00);
      read_reg(d);
      chk("R3 pointer unchanged", d, 8'h01);
      cmd_tx(8'h33, 8'h00, 0, a0, a1);
      chk("R2 unknown code nack", {7'd0, a0}, 8'h00);

      // line reset and busy gating
      g = go_cnt;
      cmd_tx(8'hB4, 8'h00, 0, a0, a1);
      chk("R2 line reset ack", {7'd0, a0}, 8'h01);
      chk("R12 go count line reset", 8'(go_cnt - g), 8'h01);
      chk("R12 op line reset", {5'd0, last_op}, 8'h00);
      read_reg(d);
      chk("R6 R9 status busy", d, 8'h09);
      cmd_tx(8'hA5, 8'h12, 1, a0, a1);
      chk("R5 write byte nack busy", {7'd0, a0}, 8'h00);
      cmd_tx(8'hD2, 8'hE1, 1, a0, a1);
      chk("R5 config nack busy", {7'd0, a0}, 8'h00);
      chk("R5 no go while busy", 8'(go_cnt - g), 8'h01);
      cmd_tx(8'hE1, 8'hF0, 1, a0, a1);
      chk("R5 set pointer while busy", {6'd0, a0, a1}, 8'h03);
      wait_idle();
      read_reg(d);
      chk("R9 presence flag", d, 8'h0A);

      // write byte
      cmd_tx(8'hA5, 8'h13, 1, a0, a1);
      chk("R12 write byte op/arg", {last_op, last_arg[4:0]}, {3'd1, 5'h13});
      chk("R12 write byte param", last_arg, 8'h13);
      read_reg(d);
      chk("R6 status after write byte", d, 8'h0B);
      wait_idle();
      read_reg(d);
      chk("R9 flags layout", d, 8'h8E);

      // read byte and repeated reads
      cmd_tx(8'h96, 8'h00, 0, a0, a1);
      chk("R12 op read byte", {5'd0, last_op}, 8'h02);
      wait_idle();
      cmd_tx(8'hE1, 8'hE1, 1, a0, a1);
      i2c_start();
      wr_byte({addr, 1'b1}, a0);
      rd_byte(1'b0, d);
      rd_byte(1'b1, d2);
      i2c_stop();
      chk("R9 read data", d, 8'h3C);
      chk("R11 repeated read", d2, 8'h3C);

      // single bit and triplet
      cmd_tx(8'h87, 8'h80, 1, a0, a1);
      chk("R12 single bit", {last_op, 5'd0}, {3'd3, 5'd0});
      chk("R12 single bit arg", last_arg, 8'h80);
      wait_idle();
      cmd_tx(8'h78, 8'h40, 1, a0, a1);
      chk("R12 triplet", {5'd0, last_op}, 8'h04);
      wait_idle();

      // extra byte
      i2c_start();
      wr_byte({addr, 1'b0}, a0);
      wr_byte(8'hE1, a0);
      wr_byte(8'hF0, a0);
      wr_byte(8'hAA, a1);
      i2c_stop();
      chk("R11 extra byte nack", {7'd0, a1}, 8'h00);

      // abort by stop and repeated start
      g = go_cnt;
      i2c_start();
      wr_byte({addr, 1'b0}, a0);
      wr_byte(8'hA5, a0);
      i2c_stop();
      i2c_start();
      wr_byte({addr, 1'b0}, a0);
      wr_byte(8'h87, a0);
      sda_m = 1; wq(); scl_m = 1; wq(); sda_m = 0; wq(); scl_m = 0; wq();
      wr_byte({addr, 1'b0}, a0);
      wr_byte(8'hE1, a0);
      i2c_stop();
      repeat (50) @(negedge clk);
      chk("R13 aborted commands", 8'(go_cnt - g), 8'h00);

      // LL sampling
      ow_line = 0;
      read_reg(d);
      chk("R10 LL low", d, 8'h00);
      ow_line = 1;
      read_reg(d);
      chk("R10 LL high", d, 8'h08);

      // device reset while busy
      cmd_tx(8'hD2, 8'h78, 1, a0, a1);
      chk("R4 cfg set before reset", {4'h0, cfg_bits}, 8'h08);
      cmd_tx(8'hB4, 8'h00, 0, a0, a1);
      g = rst_cnt;
      cmd_tx(8'hF0, 8'h00, 0, a0, a1);
      chk("R5 device reset ack while busy", {7'd0, a0}, 8'h01);
      chk("R7 reset pulse", 8'(rst_cnt - g), 8'h01);
      chk("R7 cfg cleared", {4'h0, cfg_bits}, 8'h00);
      read_reg(d);
      chk("R7 status after device reset", d, 8'h18);

      // strap follows pins
      strap = 2'b01;
      i2c_start();
      wr_byte({7'b0011001, 1'b0}, a0);
      i2c_stop();
      chk("R1 strap address ack", {7'd0, a0}, 8'h01);

      finish_run();
   end

   localparam logic [7:0] C_DEV = 8'hF0;
endmodule